// File: doc/BRIEF.md
# Two-Level DMA Request Arbiter

This block shares one expansion bus among three DMA request sources. Arbitration runs in two tiers. The first tier settles a contest between channel 0 and channel 1. The second tier settles a contest between that pair, taken as one side, and channel 2. Each tier takes a 2-bit mode at run time: alternate, favour one side, or favour the other. A single flag sets how a favoured side behaves. It either keeps winning for as long as it asks, or it gives way for one transaction each time the other side is waiting.

A decision is made only while the bus is free. The winning channel keeps its grant until it pulses its end-of-transaction line. The grant then drops for one cycle and the next decision follows. Each alternating tier remembers which of its sides won last. The first tier updates that memory only when the pair actually wins the bus.

Top module: `dta_tier_arb`

## Requirements
- R1: At most one bit of `gnt` is set at any time. `gnt` stays all-zero while no channel requests. Bit i of `gnt` grants channel i.
- R2: When `gnt` is zero and some `req` bit is set, `gnt` shows a requesting channel after the next clock edge. It holds that value, whatever `req` and the other `done` bits do, until the edge at which the granted channel's `done` bit is high. After that edge `gnt` is zero.
- R3: With `pair_mode` = 00 and both channel 0 and channel 1 requesting (channel 2 idle), the grants alternate between channel 0 and channel 1.
- R4: With `keep_fav` = 1, `pair_mode` = 01 always grants channel 1 over channel 0, and `pair_mode` = 10 always grants channel 0 over channel 1.
- R5: With `group_mode` = 00 and channel 2 contending with the pair, the grants alternate between the pair and channel 2.
- R6: With `keep_fav` = 1, `group_mode` = 01 always grants channel 2 over the pair, and `group_mode` = 10 always grants the pair over channel 2.
- R7: With `keep_fav` = 0 and a favouring mode (01 or 10) on a tier, under continuous contention that tier grants the favoured side, then the other side for one transaction, then the favoured side again.
- R8: With `keep_fav` = 1, a favoured side that keeps requesting wins every contested decision at its tier.
- R9: Mode value 11 on either tier behaves exactly as alternation (00).
- R10: After reset, `gnt` is zero. The first contested decision at each tier goes to the lower-numbered side: channel 0 at the first tier, and the pair at the second tier.
- R11: The first tier's last-winner memory changes only on decisions that the pair wins at the second tier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 3 | Per-channel bus request |
| done | input | 3 | Per-channel end-of-transaction pulse |
| pair_mode | input | 2 | First-tier mode (channel 0 vs channel 1) |
| group_mode | input | 2 | Second-tier mode (pair vs channel 2) |
| keep_fav | input | 1 | 1: favoured side keeps winning; 0: it gives way once |
| gnt | output | 3 | One-hot grant |

## Verification
In one decision cycle the second tier picks its winner and the first tier's memory update is gated on that outcome. This is provoked by having all three channels request under alternation, so that channel 2 takes the bus while the first tier holds a contested pick of its own. The result is judged by the next contest between channel 0 and channel 1 alone. End-of-transaction pulses on channels that do not hold the grant are raised during every held grant, and the grant is required to stay unchanged through them. Every mode combination is then swept against an arithmetic model.

// File: rtl/dta_pkg.sv
package dta_pkg;
  localparam int NCH    = 3;
  localparam int MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_ALT    = 2'b00;
  localparam logic [MODE_W-1:0] MODE_FAV_B  = 2'b01;
  localparam logic [MODE_W-1:0] MODE_FAV_A  = 2'b10;
  localparam logic [MODE_W-1:0] MODE_RSVD   = 2'b11;
endpackage

// File: rtl/dta_pair_pick.sv
module dta_pair_pick
  import dta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_a,
  input  logic              req_b,
  input  logic [MODE_W-1:0] mode,
  input  logic              keep_fav,
  input  logic              upd,
  output logic              win_a,
  output logic              win_b
);
  logic last_b_q, last_b_d;
  logic owe_q, owe_d;
  logic both, fav_a, fav_b, fixed, yield_mode, take_fav;

  always_comb begin
    both       = req_a & req_b;
    fav_a      = (mode == MODE_FAV_A);
    fav_b      = (mode == MODE_FAV_B);
    fixed      = fav_a | fav_b;
    yield_mode = fixed & ~keep_fav;
    take_fav   = ~(yield_mode & owe_q);
    win_a      = req_a & ~req_b;
    win_b      = req_b & ~req_a;
    if (both) begin
      if (fixed) begin
        win_a = fav_a ? take_fav : ~take_fav;
        win_b = ~win_a;
      end else begin
        win_a = last_b_q;
        win_b = ~last_b_q;
      end
    end
  end

  always_comb begin
    last_b_d = upd ? win_b : last_b_q;
    if (yield_mode) owe_d = (upd & both) ? ~owe_q : owe_q;
    else            owe_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_b_q <= 1'b1;
      owe_q    <= 1'b0;
    end else begin
      last_b_q <= last_b_d;
      owe_q    <= owe_d;
    end
  end

  p_win_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (win_a |-> req_a) and (win_b |-> req_b));

  p_fav_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && both && keep_fav && (mode == MODE_FAV_A)) |-> win_a);

  p_yield_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && both && !keep_fav && (mode == MODE_FAV_A) && win_a)
      |=> (upd && req_a && req_b && !keep_fav && (mode == MODE_FAV_A)) |-> win_b);
endmodule

// File: rtl/dta_txn_hold.sv
module dta_txn_hold #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] pick,
  input  logic [W-1:0] done,
  output logic [W-1:0] gnt,
  output logic         idle
);
  logic [W-1:0] gnt_q, gnt_d;
  logic         finish, gnt_en;

  always_comb begin
    finish = |(gnt_q & done);
    gnt_en = load | finish;
    gnt_d  = load ? pick : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gnt_q <= '0;
    else if (gnt_en) gnt_q <= gnt_d;
  end

  assign gnt  = gnt_q;
  assign idle = (gnt_q == '0);

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0 && (gnt_q & done) == '0) |=> gnt_q == $past(gnt_q));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q & done) != '0) |=> gnt_q == '0);
endmodule

// File: rtl/dta_tier_arb.sv
module dta_tier_arb
  import dta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req,
  input  logic [NCH-1:0]    done,
  input  logic [MODE_W-1:0] pair_mode,
  input  logic [MODE_W-1:0] group_mode,
  input  logic              keep_fav,
  output logic [NCH-1:0]    gnt
);
  logic           idle, decide;
  logic           l1_a, l1_b, l2_a, l2_b;
  logic [NCH-1:0] pick;

  assign decide = idle & (|req);

  dta_pair_pick u_group (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_a    (req[0] | req[1]),
    .req_b    (req[2]),
    .mode     (group_mode),
    .keep_fav (keep_fav),
    .upd      (decide),
    .win_a    (l2_a),
    .win_b    (l2_b)
  );

  dta_pair_pick u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_a    (req[0]),
    .req_b    (req[1]),
    .mode     (pair_mode),
    .keep_fav (keep_fav),
    .upd      (decide & l2_a),
    .win_a    (l1_a),
    .win_b    (l1_b)
  );

  always_comb begin
    pick    = '0;
    pick[0] = l2_a & l1_a;
    pick[1] = l2_a & l1_b;
    pick[2] = l2_b;
  end

  dta_txn_hold #(.W(NCH)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (decide),
    .pick  (pick),
    .done  (done),
    .gnt   (gnt),
    .idle  (idle)
  );

  p_serve_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req != '0) |=> (gnt & $past(req)) != '0);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req == '0) |=> gnt == '0);
endmodule

// File: tb/dta_tier_arb_tb_top.sv
`timescale 1ns/1ps
module dta_tier_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] req, done, gnt;
  logic [1:0] pair_mode, group_mode;
  logic       keep_fav;

  int n_chk  = 0;
  int n_fail = 0;
  int lw1 = 1, lw2 = 1, ow1 = 0, ow2 = 0;

  always #4 clk = ~clk;

  dta_tier_arb dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .pair_mode(pair_mode), .group_mode(group_mode),
    .keep_fav(keep_fav), .gnt(gnt)
  );

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt actual %b expected %b", tag, act, exp);
    end
  endtask

  // returns {b wins, a wins}
  function automatic logic [1:0] mpick(bit a, bit b, logic [1:0] m, bit hold, int lw, int ow);
    bit bw;
    if (!(a && b)) return {b, a};
    if (m == 2'b01 || m == 2'b10) begin
      bw = (m == 2'b01) ^ (!hold && ow == 1);
      return {bw, !bw};
    end
    return (lw == 1) ? 2'b01 : 2'b10;
  endfunction

  task automatic txn(input logic [2:0] r, input logic [1:0] pm, input logic [1:0] gm,
                     input bit hold, input int expv, input string tag);
    logic [1:0] w1, w2;
    logic [2:0] pred, exp;
    bit y1, y2;
    @(negedge clk);
    req = r; pair_mode = pm; group_mode = gm; keep_fav = hold; done = 3'b000;
    w2 = mpick(r[0] | r[1], r[2], gm, hold, lw2, ow2);
    w1 = mpick(r[0], r[1], pm, hold, lw1, ow1);
    pred = {w2[1], w2[0] & w1[1], w2[0] & w1[0]};
    exp  = (expv < 0) ? pred : expv[2:0];
    @(negedge clk);
    chk(gnt, exp, tag);
    y1 = (pm == 2'b01 || pm == 2'b10) && !hold;
    y2 = (gm == 2'b01 || gm == 2'b10) && !hold;
    if (!y1) ow1 = 0;
    if (!y2) ow2 = 0;
    if (r != 3'b000) begin
      lw2 = w2[1];
      if (y2 && (r[0] | r[1]) && r[2]) ow2 ^= 1;
      if (w2[0]) begin
        lw1 = w1[1];
        if (y1 && r[0] && r[1]) ow1 ^= 1;
      end
    end
    if (r == 3'b000) begin
      @(negedge clk);
      chk(gnt, 3'b000, "R1 idle stays zero");
      return;
    end
    done = ~pred;
    @(negedge clk);
    done = 3'b000;
    chk(gnt, pred, "R2 held through foreign done");
    done = pred; req = 3'b000;
    @(negedge clk);
    done = 3'b000;
    chk(gnt, 3'b000, "R2 released on done");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = '0; done = '0; pair_mode = '0; group_mode = '0; keep_fav = 1'b0;
    repeat (3) @(negedge clk);
    chk(gnt, 3'b000, "R10 reset grant");
    rst_n = 1'b1;

    // alternation on both tiers and pointer gating
    txn(3'b011, 2'b00, 2'b00, 0, 3'b001, "R10 R3 first pair contest");
    txn(3'b011, 2'b00, 2'b00, 0, 3'b010, "R3 alternate to ch1");
    txn(3'b111, 2'b00, 2'b00, 0, 3'b100, "R5 ch2 turn");
    txn(3'b011, 2'b00, 2'b00, 0, 3'b001, "R11 pair memory untouched");
    txn(3'b101, 2'b00, 2'b00, 0, 3'b100, "R5 ch2 vs pair");
    txn(3'b101, 2'b00, 2'b00, 0, 3'b001, "R5 pair after ch2");
    txn(3'b000, 2'b00, 2'b00, 0, 3'b000, "R1 no request");
    // favour with keep
    txn(3'b011, 2'b01, 2'b00, 1, 3'b010, "R4 ch1 favoured");
    txn(3'b011, 2'b01, 2'b00, 1, 3'b010, "R8 ch1 keeps winning");
    txn(3'b011, 2'b10, 2'b00, 1, 3'b001, "R4 ch0 favoured");
    txn(3'b101, 2'b00, 2'b01, 1, 3'b100, "R6 ch2 favoured");
    txn(3'b101, 2'b00, 2'b01, 1, 3'b100, "R8 ch2 keeps winning");
    txn(3'b101, 2'b00, 2'b10, 1, 3'b001, "R6 pair favoured");
    txn(3'b111, 2'b01, 2'b10, 1, 3'b010, "R6 pair then ch1");
    // favour with one-transaction yield
    txn(3'b011, 2'b10, 2'b00, 0, 3'b001, "R7 ch0 first");
    txn(3'b011, 2'b10, 2'b00, 0, 3'b010, "R7 ch0 yields");
    txn(3'b011, 2'b10, 2'b00, 0, 3'b001, "R7 ch0 back");
    txn(3'b101, 2'b00, 2'b01, 0, 3'b100, "R7 ch2 first");
    txn(3'b101, 2'b00, 2'b01, 0, 3'b001, "R7 ch2 yields");
    txn(3'b101, 2'b00, 2'b01, 0, 3'b100, "R7 ch2 back");
    // reserved value acts as alternation
    txn(3'b011, 2'b11, 2'b00, 0, 3'b010, "R9 pair reserved alt");
    txn(3'b011, 2'b11, 2'b00, 0, 3'b001, "R9 pair reserved alt again");
    txn(3'b101, 2'b00, 2'b11, 0, 3'b100, "R9 group reserved alt");
    txn(3'b101, 2'b00, 2'b11, 0, 3'b001, "R9 group reserved alt again");

    // sweep every mode combination against the model
    for (int pm = 0; pm < 4; pm++)
      for (int gm = 0; gm < 4; gm++)
        for (int h = 0; h < 2; h++) begin
          string tag;
          if (pm == 3 || gm == 3)      tag = "R9 sweep";
          else if (h == 1)             tag = "R8 sweep";
          else if (pm != 0 || gm != 0) tag = "R7 sweep";
          else                         tag = "R3 sweep";
          for (int pass = 0; pass < 3; pass++)
            for (int r = 1; r < 8; r++)
              txn(r[2:0], pm[1:0], gm[1:0], h[0], -1, tag);
          for (int k = 0; k < 4; k++)
            txn(3'b111, pm[1:0], gm[1:0], h[0], -1, tag);
        end

    finish_run();
  end
endmodule